// File: doc/BRIEF.md
# Don't-Care Column Resolver

This block takes one output column of a table-driven controller and makes it fully specified. Each entry of the column is 0, 1 or don't-care. The block treats the column as a closed loop of states: after the last state, execution returns to state 0. It replaces every don't-care so that the resolved column switches as seldom as possible. A per-column tag can override this and force all don't-cares to a fixed level. This suits an output that drives, for example, a clock-gate enable.

A column is loaded one entry per cycle through a valid/ready handshake. The tag and the switching mode are sampled with the entry that closes the column. Three internal passes then run over the stored column. The first scans for the boundary values needed to handle the wrap-around. The second writes the resolved values in place. The third streams the column out in state order, with a marker on the final entry. While the resolved column is being produced, the block accepts no new entries.

Top module: `dc_column_resolver`

## Requirements
- R1: After reset, `inReady` is 1, and `outValid` and `outLast` are 0.
- R2: An entry is taken on a rising edge where `inValid` and `inReady` are both high. Entries are encoded as follows: `00` means 0, `01` means 1, and `1x` means don't-care. The column ends with the entry flagged by `inLast`. `tagIn` and `earlyIn` are sampled with that entry. The tag encoding is: `00` chooses free resolution, `01` forces 0, `10` forces 1, and `11` behaves like `00`. `earlyIn` = 1 selects early switching and 0 selects late switching.
- R3: Under the force-0 tag, every don't-care resolves to 0.
- R4: Under the force-1 tag, every don't-care resolves to 1.
- R5: Under free resolution, a don't-care run whose nearest defined neighbours are equal takes that value, in either mode.
- R6: In early mode, a run between unequal neighbours takes the value of the defined entry that follows it.
- R7: In late mode, such a run takes the value of the defined entry that precedes it.
- R8: Neighbours are found circularly. A run that touches the end or the start of the column uses defined entries from the other end.
- R9: A column made only of don't-cares resolves to all 0 under free resolution.
- R10: The output delivers exactly one entry per loaded entry, in state order, on consecutive cycles. `outLast` is high only on the final entry. `inReady` is low from the cycle after the closing entry is accepted until the final entry has been emitted.
- R11: Defined entries are passed through unchanged under every tag and mode.
- R12: A column of `DEPTH` entries closes on its `DEPTH`-th entry even when `inLast` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Entry offered |
| inReady | output | 1 | Block accepts entries |
| inData | input | 2 | Ternary entry code |
| inLast | input | 1 | Entry closes the column |
| tagIn | input | 2 | Column constraint tag |
| earlyIn | input | 1 | 1 = early switching, 0 = late switching |
| outValid | output | 1 | Resolved entry present |
| outBit | output | 1 | Resolved entry value |
| outLast | output | 1 | Final entry of the column |

## Verification
The bench uses the default `DEPTH` of 16. This lets a column fill the buffer completely and close without `inLast`, so the length cap is tested. Short columns of one to five entries exercise the wrap-around. In those columns a don't-care run spans the physical end of the buffer, which tests seeding from the opposite end in both switching modes. Single-entry and all-don't-care columns cover the degenerate seeds.

// File: rtl/dcres_pkg.sv
package dcres_pkg;

  typedef enum logic [1:0] {
    TAG_FREE     = 2'b00,
    TAG_ZERO     = 2'b01,
    TAG_ONE      = 2'b10,
    TAG_FREE_ALT = 2'b11
  } tag_e;

  typedef enum logic [1:0] {
    PH_LOAD,
    PH_SCAN,
    PH_FILL,
    PH_EMIT
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // store incoming entry
    logic scanEn;    // boundary scan step
    logic fillEn;    // resolve step
    logic fillFirst; // first resolve step: use seed
    logic emitEn;    // stream step
    logic emitLast;  // stream step is the final entry
    logic early;     // early switching selected
    logic forceEn;   // forced tag active
    logic forceVal;  // forced level
  } ctrl_s;

endpackage

// File: rtl/dcres_ctrl.sv
module dcres_ctrl
  import dcres_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [1:0]       tagIn,
  input  logic             earlyIn,
  output logic             inReady,
  output ctrl_s            strb,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_MAX = IDX_W'(DEPTH - 1);

  phase_e           phase;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] lastIdx;
  logic             earlyR;
  tag_e             tagR;
  logic             firstFill;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_LOAD;
      cnt       <= '0;
      lastIdx   <= '0;
      earlyR    <= 1'b0;
      tagR      <= TAG_FREE;
      firstFill <= 1'b0;
    end else begin
      case (phase)
        PH_LOAD: begin
          if (inValid) begin
            earlyR <= earlyIn;
            tagR   <= tag_e'(tagIn);
            if (inLast || cnt == LAST_MAX) begin
              lastIdx <= cnt;
              cnt     <= '0;
              phase   <= PH_SCAN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_SCAN: begin
          if (cnt == lastIdx) begin
            phase     <= PH_FILL;
            firstFill <= 1'b1;
            cnt       <= earlyR ? lastIdx : '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FILL: begin
          firstFill <= 1'b0;
          if (earlyR ? (cnt == '0) : (cnt == lastIdx)) begin
            phase <= PH_EMIT;
            cnt   <= '0;
          end else begin
            cnt <= earlyR ? cnt - 1'b1 : cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == lastIdx) begin
            phase <= PH_LOAD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb.wrEn      = (phase == PH_LOAD) && inValid;
    strb.scanEn    = (phase == PH_SCAN);
    strb.fillEn    = (phase == PH_FILL);
    strb.fillFirst = (phase == PH_FILL) && firstFill;
    strb.emitEn    = (phase == PH_EMIT);
    strb.emitLast  = (phase == PH_EMIT) && (cnt == lastIdx);
    strb.early     = earlyR;
    strb.forceEn   = (tagR == TAG_ZERO) || (tagR == TAG_ONE);
    strb.forceVal  = (tagR == TAG_ONE);
  end

  assign inReady = (phase == PH_LOAD);
  assign idx     = cnt;

  AST_IDX_IN_COLUMN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scanEn || strb.fillEn || strb.emitEn) |-> (idx <= lastIdx)); // R10

  AST_BACK_TO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitLast |=> inReady); // R10

  AST_LENGTH_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && cnt == LAST_MAX) |=> !inReady); // R12

endmodule

// File: rtl/dcres_datapath.sv
module dcres_datapath
  import dcres_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_s            strb,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       inData,
  output logic             outValid,
  output logic             outBit,
  output logic             outLast
);

  logic [1:0] colMem [DEPTH];

  logic       anyDef;
  logic       firstDef;
  logic       lastDef;
  logic       held;

  logic [1:0] cur;
  logic       curDef;
  logic       seed;
  logic       carry;
  logic       fillVal;

  always_comb begin
    cur     = colMem[idx];
    curDef  = !cur[1];
    // early: next defined wraps to first defined; late: previous wraps to last
    seed    = anyDef ? (strb.early ? firstDef : lastDef) : 1'b0;
    carry   = strb.fillFirst ? seed : held;
    fillVal = curDef ? cur[0] : (strb.forceEn ? strb.forceVal : carry);
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      colMem[idx] <= inData;
    end else if (strb.fillEn) begin
      colMem[idx] <= {1'b0, fillVal};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      anyDef   <= 1'b0;
      firstDef <= 1'b0;
      lastDef  <= 1'b0;
      held     <= 1'b0;
    end else begin
      if (strb.scanEn) begin
        if (curDef) begin
          if (idx == '0 || !anyDef) firstDef <= cur[0];
          lastDef <= cur[0];
          anyDef  <= 1'b1;
        end else if (idx == '0) begin
          anyDef <= 1'b0;
        end
      end
      if (strb.fillEn) held <= fillVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBit   <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strb.emitEn;
      outBit   <= strb.emitEn ? cur[0] : 1'b0;
      outLast  <= strb.emitLast;
    end
  end

  AST_NO_DC_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitEn |-> !cur[1]); // R10

  AST_DEFINED_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillEn && curDef) |=> (colMem[$past(idx)] == $past(cur))); // R11

endmodule

// File: rtl/dc_column_resolver.sv
module dc_column_resolver
  import dcres_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [1:0] inData,
  input  logic       inLast,
  input  logic [1:0] tagIn,
  input  logic       earlyIn,
  output logic       outValid,
  output logic       outBit,
  output logic       outLast
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctrl_s            strb;
  logic [IDX_W-1:0] idx;

  dcres_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .tagIn   (tagIn),
    .earlyIn (earlyIn),
    .inReady (inReady),
    .strb    (strb),
    .idx     (idx)
  );

  dcres_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .idx      (idx),
    .inData   (inData),
    .outValid (outValid),
    .outBit   (outBit),
    .outLast  (outLast)
  );

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R10

endmodule

// File: tb/dc_column_resolver_tb.sv
module dc_column_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [1:0] inData = 2'b00;
  logic       inLast = 1'b0;
  logic [1:0] tagIn = 2'b00;
  logic       earlyIn = 1'b0;
  logic       outValid;
  logic       outBit;
  logic       outLast;

  int passCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  logic [1:0] col [16];
  int         colLen;
  logic [1:0] expQ[$];
  string      reqQ[$];

  always #4 clk = ~clk; // 125 MHz

  dc_column_resolver #(.DEPTH(16)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .tagIn(tagIn), .earlyIn(earlyIn),
    .outValid(outValid), .outBit(outBit), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // pattern: '0','1', 'X' = 10, 'Y' = 11
  task automatic setPat(input string s);
    colLen = s.len();
    for (int i = 0; i < colLen; i++) begin
      case (s[i])
        "0":     col[i] = 2'b00;
        "1":     col[i] = 2'b01;
        "Y":     col[i] = 2'b11;
        default: col[i] = 2'b10;
      endcase
    end
  endtask

  task automatic runColumn(input string pat, input logic [1:0] t,
                           input logic e, input bit noLast, input string req);
    setPat(pat);
    for (int i = 0; i < colLen; i++) begin
      logic v;
      bit found;
      found = 0;
      v = 1'b0;
      if (!col[i][1]) v = col[i][0];
      else if (t == 2'b01) v = 1'b0;
      else if (t == 2'b10) v = 1'b1;
      else begin
        for (int k = 1; k < colLen; k++) begin
          int j;
          j = e ? (i + k) % colLen : (i - k + colLen) % colLen;
          if (!found && !col[j][1]) begin
            v = col[j][0];
            found = 1;
          end
        end
      end
      expQ.push_back({v, (i == colLen - 1) ? 1'b1 : 1'b0});
      reqQ.push_back(req);
    end
    for (int i = 0; i < colLen; i++) begin
      while (!inReady) @(negedge clk);
      inValid = 1'b1;
      inData  = col[i];
      inLast  = !noLast && (i == colLen - 1);
      tagIn   = t;
      earlyIn = e;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    check(inReady == 1'b0, "R10", "inReady after closing entry", inReady, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(0, "R10", "unexpected output entry", 1, 0);
      end else begin
        logic [1:0] ex;
        string rq;
        ex = expQ.pop_front();
        rq = reqQ.pop_front();
        check({outBit, outLast} == ex, rq, "{bit,last}", {outBit, outLast}, ex);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(outLast == 1'b0, "R1", "outLast after reset", outLast, 0);

    runColumn("0XX1", 2'b00, 1'b0, 0, "R7");
    runColumn("0XX1", 2'b00, 1'b1, 0, "R6");
    runColumn("1XX10", 2'b00, 1'b1, 0, "R5");
    runColumn("1XX10", 2'b00, 1'b0, 0, "R5");
    runColumn("X10X", 2'b00, 1'b0, 0, "R8");
    runColumn("X10X", 2'b00, 1'b1, 0, "R8");
    runColumn("X1X1", 2'b01, 1'b1, 0, "R3");
    runColumn("0X0Y", 2'b10, 1'b0, 0, "R4");
    runColumn("01Y0X1", 2'b10, 1'b1, 0, "R11");
    runColumn("0X0Y", 2'b11, 1'b0, 0, "R2");
    runColumn("XXX", 2'b00, 1'b1, 0, "R9");
    runColumn("1", 2'b00, 1'b0, 0, "R10");
    runColumn("X", 2'b00, 1'b1, 0, "R9");
    runColumn("X01XX1X0XXXX1X0X", 2'b00, 1'b1, 1, "R12");
    runColumn("X01XX1X0XXXX1X0X", 2'b00, 1'b0, 1, "R12");

    while (!inReady || expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10", "entries left undelivered", expQ.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

endmodule